// File: doc/BRIEF.md
# Per-Bank Row Open Timer

This block watches every bank of one DRAM channel, sixteen in all (four ranks of four banks), and reports how long each open row has been active. It takes activate, single-bank precharge and rank-wide precharge events, each tagged with rank and bank. For every bank it keeps two independent counters. The first counts DRAM clocks and holds the bank's precharge-allowed flag low until a programmable minimum activate-to-precharge time has passed. The second counts one-microsecond ticks while the bank is open and raises a forced-close request once 120 microseconds have passed, so the scheduler has to close that row.

The command scheduler reads the per-bank flags before it issues a precharge, and it treats a forced-close request as an urgent precharge demand. A refresh engine that closes a whole rank, for example on an urgent refresh, reports this through the rank-wide precharge input. That input closes all four banks of the rank at once. An activate to a bank that is already open is a scheduler bug, so the block flags it.

Top module: `row_open_timer`

## Requirements
- R1: After reset no bank is open, no forced-close request is active, every precharge-allowed flag is high, and the error output is low.
- R2: An activate to rank r, bank b sets bit index 4*r+b of the open-bank output after the clock edge that samples it.
- R3: With a minimum code N in the range 4 to 15, a bank's precharge-allowed flag is low from the edge that samples its activate until the N-th clock edge after it. The flag is high right after that N-th edge.
- R4: The reserved minimum codes 0 to 3 behave exactly as code 4, so the flag rises 4 edges after the activate.
- R5: Once high, a bank's precharge-allowed flag stays high through a precharge to that bank until the next activate to it.
- R6: A bank's forced-close request goes high on the clock edge that samples the 120th microsecond tick counted while the bank is open. It then stays high until the bank is closed or activated again.
- R7: Ticks seen while a bank is closed, and a tick on the same edge as the activate, are not counted toward that bank's 120.
- R8: A precharge to a bank clears its open bit and its forced-close request on the edge that samples it.
- R9: A rank-wide precharge clears the open bits and forced-close requests of all four banks of that rank in one edge, and leaves other ranks unchanged.
- R10: An activate to a bank that is already open drives the error output high for exactly the one cycle after the activate edge. Both of that bank's counters restart from that edge.
- R11: Clock edges on which the tick input is low do not advance any bank's maximum-time count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | Activate event this cycle |
| act_rank | input | 2 | Rank of the activate |
| act_bank | input | 2 | Bank of the activate |
| pre_valid | input | 1 | Single-bank precharge this cycle |
| pre_rank | input | 2 | Rank of the precharge |
| pre_bank | input | 2 | Bank of the precharge |
| pall_valid | input | 1 | Rank-wide precharge this cycle |
| pall_rank | input | 2 | Rank closed by the rank-wide precharge |
| min_open_code | input | 4 | Minimum activate-to-precharge time in DRAM clocks |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| bank_open | output | 16 | Per-bank open flag, index 4*rank+bank |
| pre_ok | output | 16 | Per-bank precharge-allowed flag |
| force_close | output | 16 | Per-bank forced-close request |
| act_err | output | 1 | Activate to an already open bank, one cycle late |

## Verification
A corrupted clock counter shows at the precharge-allowed flags within at most fifteen cycles, because the flag rises either too early or too late relative to the activate edge. A corrupted open bit or tick count shows only when a forced-close request appears. That can be as late as 120 ticks after the activate, so the forced-close checks sample both the 119th and the 120th counted tick. A decode error in rank or bank lands on the wrong bit index and becomes visible on the next edge.

// File: rtl/rot_pkg.sv
package rot_pkg;

  // smallest legal minimum-open code; smaller codes are clamped up to it
  localparam int unsigned ROT_MIN_LEGAL = 4;

  // one microsecond tick count that forces a close
  localparam int unsigned ROT_MAX_TICKS = 120;

  function automatic int unsigned rot_clamp(input int unsigned code,
                                            input int unsigned floor_v);
    return (code < floor_v) ? floor_v : code;
  endfunction

endpackage

// File: rtl/rot_cmd_decode.sv
module rot_cmd_decode #(
  parameter int unsigned NUM_RANKS      = 4,
  parameter int unsigned BANKS_PER_RANK = 4,
  parameter int unsigned RW             = 2,
  parameter int unsigned BW             = 2,
  localparam int unsigned NB            = NUM_RANKS * BANKS_PER_RANK
) (
  input  logic          act_valid,
  input  logic [RW-1:0] act_rank,
  input  logic [BW-1:0] act_bank,
  input  logic          pre_valid,
  input  logic [RW-1:0] pre_rank,
  input  logic [BW-1:0] pre_bank,
  input  logic          pall_valid,
  input  logic [RW-1:0] pall_rank,
  output logic [NB-1:0] act_hit,
  output logic [NB-1:0] close_hit
);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic rank_all;
    assign rank_all = pall_valid && (pall_rank == RW'(r));
    for (genvar b = 0; b < BANKS_PER_RANK; b++) begin : g_bank
      localparam int unsigned IDX = r * BANKS_PER_RANK + b;
      assign act_hit[IDX]   = act_valid && (act_rank == RW'(r)) && (act_bank == BW'(b));
      assign close_hit[IDX] = rank_all ||
                              (pre_valid && (pre_rank == RW'(r)) && (pre_bank == BW'(b)));
    end
  end

endmodule

// File: rtl/rot_min_timer.sv
module rot_min_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_hit,
  input  logic [CW-1:0] min_clks,
  output logic          pre_ok
);

  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // restart on activate, otherwise count up and hold at saturation
  always_comb begin
    cnt_en = act_hit || (cnt_q != SAT);
    cnt_d  = act_hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= SAT;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pre_ok = (cnt_q >= min_clks);

  // an activate always blocks precharge on the following cycle
  assert_min_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_hit |=> !pre_ok);

endmodule

// File: rtl/rot_max_timer.sv
module rot_max_timer #(
  parameter int unsigned MAX_TICKS = 120,
  parameter bit          MAX_EN    = 1'b1,
  localparam int unsigned TW       = $clog2(MAX_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_hit,
  input  logic close_hit,
  input  logic tick,
  output logic open,
  output logic force_close
);

  logic open_q, open_d;

  // activate wins over a close on the same edge
  always_comb begin
    if (act_hit)        open_d = 1'b1;
    else if (close_hit) open_d = 1'b0;
    else                open_d = open_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  assign open = open_q;

  if (MAX_EN) begin : g_max
    localparam logic [TW-1:0] LIMIT = TW'(MAX_TICKS);

    logic [TW-1:0] tcnt_q, tcnt_d;
    logic          frc_q, frc_d;
    logic          step, tcnt_en, frc_en;

    always_comb begin
      step    = open_q && tick && (tcnt_q != LIMIT);
      tcnt_en = act_hit || close_hit || step;
      tcnt_d  = (act_hit || close_hit) ? '0 : tcnt_q + 1'b1;
      frc_en  = act_hit || close_hit || (step && (tcnt_q == LIMIT - 1'b1));
      frc_d   = !(act_hit || close_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tcnt_q <= '0;
        frc_q  <= 1'b0;
      end else begin
        if (tcnt_en) tcnt_q <= tcnt_d;
        if (frc_en)  frc_q  <= frc_d;
      end
    end

    assign force_close = frc_q;

    assert_tick_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tcnt_q <= LIMIT);

    assert_force_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frc_q |-> (tcnt_q == LIMIT));

  end else begin : g_nomax
    assign force_close = 1'b0;
  end

  assert_force_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_close |-> open_q);

  assert_close_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (close_hit && !act_hit) |=> (!open_q && !force_close));

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_hit |=> (open_q && !force_close));

endmodule

// File: rtl/row_open_timer.sv
module row_open_timer
  import rot_pkg::*;
#(
  parameter int unsigned NUM_RANKS      = 4,
  parameter int unsigned BANKS_PER_RANK = 4,
  parameter int unsigned CODE_W         = 4,
  parameter int unsigned MIN_LEGAL      = ROT_MIN_LEGAL,
  parameter int unsigned MAX_TICKS      = ROT_MAX_TICKS,
  parameter bit          MAX_EN         = 1'b1,
  localparam int unsigned NB            = NUM_RANKS * BANKS_PER_RANK,
  localparam int unsigned RW            = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int unsigned BW            = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_valid,
  input  logic [RW-1:0]     act_rank,
  input  logic [BW-1:0]     act_bank,
  input  logic              pre_valid,
  input  logic [RW-1:0]     pre_rank,
  input  logic [BW-1:0]     pre_bank,
  input  logic              pall_valid,
  input  logic [RW-1:0]     pall_rank,
  input  logic [CODE_W-1:0] min_open_code,
  input  logic              us_tick,
  output logic [NB-1:0]     bank_open,
  output logic [NB-1:0]     pre_ok,
  output logic [NB-1:0]     force_close,
  output logic              act_err
);

  logic [NB-1:0]     act_hit, close_hit;
  logic [CODE_W-1:0] min_eff;
  logic              err_d, err_q;

  // reserved low codes are raised to the legal floor, never shortened
  assign min_eff = CODE_W'(rot_clamp(int'(min_open_code), MIN_LEGAL));

  rot_cmd_decode #(
    .NUM_RANKS      (NUM_RANKS),
    .BANKS_PER_RANK (BANKS_PER_RANK),
    .RW             (RW),
    .BW             (BW)
  ) u_decode (
    .act_valid  (act_valid),
    .act_rank   (act_rank),
    .act_bank   (act_bank),
    .pre_valid  (pre_valid),
    .pre_rank   (pre_rank),
    .pre_bank   (pre_bank),
    .pall_valid (pall_valid),
    .pall_rank  (pall_rank),
    .act_hit    (act_hit),
    .close_hit  (close_hit)
  );

  for (genvar i = 0; i < NB; i++) begin : g_bank
    rot_min_timer #(
      .CW (CODE_W)
    ) u_min (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_hit  (act_hit[i]),
      .min_clks (min_eff),
      .pre_ok   (pre_ok[i])
    );

    rot_max_timer #(
      .MAX_TICKS (MAX_TICKS),
      .MAX_EN    (MAX_EN)
    ) u_max (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_hit     (act_hit[i]),
      .close_hit   (close_hit[i]),
      .tick        (us_tick),
      .open        (bank_open[i]),
      .force_close (force_close[i])
    );
  end

  // protocol error: activate landing on a row that is still open
  assign err_d = |(act_hit & bank_open);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign act_err = err_q;

  assert_act_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_hit));

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    act_err |-> $past(act_valid));

endmodule

// File: tb/tb_row_open_timer.sv
module tb_row_open_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        act_valid, pre_valid, pall_valid, us_tick;
  logic [1:0]  act_rank, act_bank, pre_rank, pre_bank, pall_rank;
  logic [3:0]  min_open_code;
  logic [15:0] bank_open, pre_ok, force_close;
  logic        act_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  row_open_timer dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .act_valid     (act_valid),
    .act_rank      (act_rank),
    .act_bank      (act_bank),
    .pre_valid     (pre_valid),
    .pre_rank      (pre_rank),
    .pre_bank      (pre_bank),
    .pall_valid    (pall_valid),
    .pall_rank     (pall_rank),
    .min_open_code (min_open_code),
    .us_tick       (us_tick),
    .bank_open     (bank_open),
    .pre_ok        (pre_ok),
    .force_close   (force_close),
    .act_err       (act_err)
  );

  // table: minimum code, rank, bank, expected edges until precharge allowed
  localparam int NV = 6;
  localparam int V_CODE [NV] = '{4, 9, 15, 0, 3, 2};
  localparam int V_RANK [NV] = '{0, 1, 2, 3, 0, 2};
  localparam int V_BANK [NV] = '{0, 3, 1, 2, 1, 3};
  localparam int V_EXP  [NV] = '{4, 9, 15, 4, 4, 4};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_act(input int r, input int b);
    act_valid = 1'b1; act_rank = 2'(r); act_bank = 2'(b);
    step();
    act_valid = 1'b0;
  endtask

  task automatic do_pre(input int r, input int b);
    pre_valid = 1'b1; pre_rank = 2'(r); pre_bank = 2'(b);
    step();
    pre_valid = 1'b0;
  endtask

  task automatic do_pall(input int r);
    pall_valid = 1'b1; pall_rank = 2'(r);
    step();
    pall_valid = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    act_valid = 1'b0; pre_valid = 1'b0; pall_valid = 1'b0; us_tick = 1'b0;
    act_rank = '0; act_bank = '0; pre_rank = '0; pre_bank = '0; pall_rank = '0;
    min_open_code = 4'd4;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 open",  32'(bank_open),   32'h0);
    chk("R1 force", 32'(force_close), 32'h0);
    chk("R1 preok", 32'(pre_ok),      32'hFFFF);
    chk("R1 err",   32'(act_err),     32'h0);

    // table walk: R2, R3, R4, R5, R8
    for (int i = 0; i < NV; i++) begin
      int idx;
      string rq;
      idx = V_RANK[i] * 4 + V_BANK[i];
      rq  = (V_CODE[i] < 4) ? "R4" : "R3";
      min_open_code = 4'(V_CODE[i]);
      do_act(V_RANK[i], V_BANK[i]);
      chk("R2 open bit", 32'(bank_open), 32'(1) << idx);
      chk("R10 no err on fresh act", 32'(act_err), 32'h0);
      repeat (V_EXP[i] - 1) step();
      chk({rq, " still blocked"}, 32'(pre_ok[idx]), 32'h0);
      step();
      chk({rq, " allowed"}, 32'(pre_ok[idx]), 32'h1);
      do_pre(V_RANK[i], V_BANK[i]);
      chk("R8 closed", 32'(bank_open), 32'h0);
      repeat (3) step();
      chk("R5 flag held", 32'(pre_ok[idx]), 32'h1);
    end
    min_open_code = 4'd6;

    // R7: ticks while closed do not count; R6 exact 120th tick and hold
    us_tick = 1'b1;
    repeat (200) step();
    chk("R7 closed no force", 32'(force_close), 32'h0);
    do_act(1, 1);
    repeat (119) step();
    chk("R7 119 ticks", 32'(force_close), 32'h0);
    step();
    chk("R6 120 ticks", 32'(force_close), 32'h0020);
    repeat (10) step();
    chk("R6 held", 32'(force_close), 32'h0020);
    do_pre(1, 1);
    chk("R8 force cleared", 32'(force_close), 32'h0);
    chk("R8 open cleared", 32'(bank_open), 32'h0);

    // R11: idle tick cycles do not advance
    us_tick = 1'b0;
    do_act(0, 2);
    us_tick = 1'b1;
    repeat (60) step();
    us_tick = 1'b0;
    repeat (50) step();
    chk("R11 paused", 32'(force_close), 32'h0);
    us_tick = 1'b1;
    repeat (59) step();
    chk("R11 119 counted", 32'(force_close), 32'h0);
    step();
    chk("R11 120 counted", 32'(force_close), 32'h0004);
    do_pre(0, 2);

    // R10: activate to open bank flags error and restarts counters
    do_act(3, 0);
    repeat (100) step();
    do_act(3, 0);
    chk("R10 err", 32'(act_err), 32'h1);
    chk("R10 min restart", 32'(pre_ok[12]), 32'h0);
    step();
    chk("R10 err one cycle", 32'(act_err), 32'h0);
    repeat (118) step();
    chk("R10 max restart", 32'(force_close), 32'h0);
    step();
    chk("R10 force after restart", 32'(force_close), 32'h1000);
    do_pre(3, 0);

    // R9: rank-wide close
    us_tick = 1'b0;
    for (int b = 0; b < 4; b++) do_act(1, b);
    do_act(2, 0);
    chk("R2 several open", 32'(bank_open), 32'h01F0);
    us_tick = 1'b1;
    repeat (120) step();
    us_tick = 1'b0;
    chk("R6 several forced", 32'(force_close), 32'h01F0);
    do_pall(1);
    chk("R9 rank closed", 32'(bank_open), 32'h0100);
    chk("R9 rank force cleared", 32'(force_close), 32'h0100);
    do_pre(2, 0);
    chk("R8 last close", 32'(bank_open | force_close), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule